// File: doc/BRIEF.md
# Debug Comparator Register Window

This block holds the programming registers of four debug comparators, numbered 0 to 3 (A, B, C and D). A byte-wide register bus reaches all of them through one 8-byte window. A 2-bit window selector is driven from a neighbouring control register and chooses which comparator the window shows. The four comparators are not the same size:

- Comparators A and C are full. Each holds a control byte, a 24-bit compare address, a 16-bit compare data value and a 16-bit data mask.
- Comparators B and D are lite. Each holds only a control byte and a 24-bit compare address.

When a lite comparator is selected, the data and mask positions of the window read back as zero and ignore writes. The two kinds of comparator also implement different sets of control bits.

Every register value is driven continuously to the comparator logic, together with one enable bit per comparator. The compare logic itself lies outside this block.

The register bus has no back-pressure and carries no data stream:
- A request is taken in every cycle in which `req_valid` is high, and there is no ready signal.
- A write updates the selected register at the clock edge that samples the request.
- A read returns its byte one cycle later, with `rsp_valid` high for exactly that cycle.
- `win_sel` is sampled in the same cycle as the request it steers.

Top module: `dbgw_window`

## Requirements
- R1: After reset, every register is zero. `cmp_en` is 0 and every read of every window byte returns 0.
- R2: The value of `win_sel` picks the comparator that a request reaches: 0 selects A, 1 selects B, 2 selects C and 3 selects D. A write changes only the selected comparator.
- R3: Window offset 0 is the control byte. Offsets 1, 2 and 3 are the address bytes, from high to low, and they appear on that comparator's 24-bit slice of `cmp_addr` as bits 23:16, 15:8 and 7:0.
- R4: On A and C, offsets 4 and 5 are compare data bits 15:8 and 7:0, and offsets 6 and 7 are mask bits 15:8 and 7:0. They appear on the comparator's 16-bit slices of `cmp_data` and `cmp_mask`.
- R5: On B and D, offsets 4 to 7 always read 0 and writes to them change nothing. The `cmp_data` and `cmp_mask` slices of B and D stay 0.
- R6: On A and C, control bits 5:0 are writable. Bits 7:6 always read 0 and appear as 0 on `cmp_ctl`.
- R7: On B and D, control bits 3:0 are writable. Bits 7:4 always read 0 and appear as 0 on `cmp_ctl`.
- R8: `cmp_en[i]` equals bit 0 of comparator i's control byte. A comparator is enabled only while that bit is 1.
- R9: A read accepted in cycle n raises `rsp_valid` in cycle n+1 only, with the byte on `rsp_rdata`. Writes never raise `rsp_valid`.
- R10: A read that directly follows a write to the same location returns the newly written value, after the masking of R5 to R7 is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_sel | input | 2 | Comparator shown in the window (0 = A, 1 = B, 2 = C, 3 = D) |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | 3 | Byte offset within the window |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 8 | Read data |
| cmp_en | output | 4 | Per-comparator enable, bit i = comparator i |
| cmp_ctl | output | 32 | Control bytes, comparator i at bits 8i+7:8i |
| cmp_addr | output | 96 | Compare addresses, comparator i at bits 24i+23:24i |
| cmp_data | output | 64 | Compare data, comparator i at bits 16i+15:16i (zero for B and D) |
| cmp_mask | output | 64 | Data masks, comparator i at bits 16i+15:16i (zero for B and D) |

## Verification
Every register drives a port all the time. A corrupted register, a byte written into the wrong comparator or a wrong byte order therefore shows on `cmp_addr`, `cmp_data`, `cmp_mask` or `cmp_en` in the cycle after the write that caused it. The bench writes every window byte of every comparator with all-ones, with a distinct per-position pattern and with zeros. After each write it reads the byte back at once, and after each pass it reads all 32 positions and compares every output slice. A write that leaks into a lite comparator's data area, or an unimplemented control bit that sticks, shows on the next readback of that position.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;
  localparam int NUM_CMP    = 4;
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = 3;
  localparam int DATA_BYTES = 2;
  localparam int WIN_BYTES  = 1 + ADDR_BYTES + 2 * DATA_BYTES;
  localparam int OFF_W      = $clog2(WIN_BYTES);
  localparam int SEL_W      = $clog2(NUM_CMP);
  localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
  localparam int DATA_W     = DATA_BYTES * BYTE_W;

  localparam int ADDR_OFF0  = 1;
  localparam int DATA_OFF0  = ADDR_OFF0 + ADDR_BYTES;
  localparam int MASK_OFF0  = DATA_OFF0 + DATA_BYTES;

  localparam logic [BYTE_W-1:0] CTL_MASK_FULL = 8'h3F;
  localparam logic [BYTE_W-1:0] CTL_MASK_LITE = 8'h0F;
  localparam int                EN_BIT        = 0;

  typedef enum logic [1:0] {
    FLD_CTL  = 2'd0,
    FLD_ADDR = 2'd1,
    FLD_DATA = 2'd2,
    FLD_MASK = 2'd3
  } fld_e;

  // Even-numbered comparators carry data and mask registers.
  function automatic bit cmp_is_full(int idx);
    return (idx % 2) == 0;
  endfunction

  function automatic fld_e field_of(logic [OFF_W-1:0] off);
    if (int'(off) < ADDR_OFF0)      return FLD_CTL;
    else if (int'(off) < DATA_OFF0) return FLD_ADDR;
    else if (int'(off) < MASK_OFF0) return FLD_DATA;
    else                            return FLD_MASK;
  endfunction
endpackage

// File: rtl/dbgw_decode.sv
module dbgw_decode
  import dbgw_pkg::*;
(
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [SEL_W-1:0] win_sel,
  output logic [NUM_CMP-1:0] wr_en
);
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_wr
    assign wr_en[i] = req_valid && req_write && (win_sel == SEL_W'(i));
  end
endmodule

// File: rtl/dbgw_bank.sv
module dbgw_bank
  import dbgw_pkg::*;
#(
  parameter bit                FULL     = 1'b1,
  parameter logic [BYTE_W-1:0] CTL_MASK = CTL_MASK_FULL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  off,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] ctl_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] mask_q
);
  fld_e wr_fld;
  fld_e rd_fld;
  assign wr_fld = field_of(off);
  assign rd_fld = field_of(off);

  // Control byte: only implemented bits are stored.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ctl_q <= '0;
    else if (wr_en && (wr_fld == FLD_CTL)) ctl_q <= wdata & CTL_MASK;
  end

  // Address bytes, window order high to low.
  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_addr
    localparam int LSB = (ADDR_BYTES - 1 - k) * BYTE_W;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        addr_q[LSB +: BYTE_W] <= '0;
      else if (wr_en && (int'(off) == ADDR_OFF0 + k))
        addr_q[LSB +: BYTE_W] <= wdata;
    end
  end

  if (FULL) begin : g_full
    for (genvar k = 0; k < DATA_BYTES; k++) begin : g_dm
      localparam int LSB = (DATA_BYTES - 1 - k) * BYTE_W;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          data_q[LSB +: BYTE_W] <= '0;
        else if (wr_en && (int'(off) == DATA_OFF0 + k))
          data_q[LSB +: BYTE_W] <= wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mask_q[LSB +: BYTE_W] <= '0;
        else if (wr_en && (int'(off) == MASK_OFF0 + k))
          mask_q[LSB +: BYTE_W] <= wdata;
      end
    end
  end else begin : g_lite
    assign data_q = '0;
    assign mask_q = '0;
  end

  // Read byte for the requested offset.
  always_comb begin
    rd_byte = '0;
    unique case (rd_fld)
      FLD_CTL: rd_byte = ctl_q;
      FLD_ADDR: begin
        for (int k = 0; k < ADDR_BYTES; k++)
          if (int'(off) == ADDR_OFF0 + k)
            rd_byte = addr_q[(ADDR_BYTES - 1 - k) * BYTE_W +: BYTE_W];
      end
      FLD_DATA: begin
        for (int k = 0; k < DATA_BYTES; k++)
          if (int'(off) == DATA_OFF0 + k)
            rd_byte = data_q[(DATA_BYTES - 1 - k) * BYTE_W +: BYTE_W];
      end
      FLD_MASK: begin
        for (int k = 0; k < DATA_BYTES; k++)
          if (int'(off) == MASK_OFF0 + k)
            rd_byte = mask_q[(DATA_BYTES - 1 - k) * BYTE_W +: BYTE_W];
      end
      default: rd_byte = '0;
    endcase
  end
endmodule

// File: rtl/dbgw_rdmux.sv
module dbgw_rdmux
  import dbgw_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [SEL_W-1:0]          win_sel,
  input  logic [NUM_CMP*BYTE_W-1:0] bank_bytes,
  output logic                      rsp_valid,
  output logic [BYTE_W-1:0]         rsp_rdata
);
  logic [BYTE_W-1:0] pick;
  logic              rd_req;

  assign rd_req = req_valid && !req_write;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_CMP; i++)
      if (win_sel == SEL_W'(i)) pick = bank_bytes[i*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= pick;
    end
  end
endmodule

// File: rtl/dbgw_window.sv
module dbgw_window
  import dbgw_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SEL_W-1:0]          win_sel,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [OFF_W-1:0]          req_off,
  input  logic [BYTE_W-1:0]         req_wdata,
  output logic                      rsp_valid,
  output logic [BYTE_W-1:0]         rsp_rdata,
  output logic [NUM_CMP-1:0]        cmp_en,
  output logic [NUM_CMP*BYTE_W-1:0] cmp_ctl,
  output logic [NUM_CMP*ADDR_W-1:0] cmp_addr,
  output logic [NUM_CMP*DATA_W-1:0] cmp_data,
  output logic [NUM_CMP*DATA_W-1:0] cmp_mask
);
  logic [NUM_CMP-1:0]        wr_en;
  logic [NUM_CMP*BYTE_W-1:0] bank_bytes;

  dbgw_decode u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .win_sel   (win_sel),
    .wr_en     (wr_en)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    localparam bit                FULL_I = cmp_is_full(i);
    localparam logic [BYTE_W-1:0] MASK_I = FULL_I ? CTL_MASK_FULL : CTL_MASK_LITE;
    dbgw_bank #(
      .FULL     (FULL_I),
      .CTL_MASK (MASK_I)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en[i]),
      .off     (req_off),
      .wdata   (req_wdata),
      .rd_byte (bank_bytes[i*BYTE_W +: BYTE_W]),
      .ctl_q   (cmp_ctl[i*BYTE_W +: BYTE_W]),
      .addr_q  (cmp_addr[i*ADDR_W +: ADDR_W]),
      .data_q  (cmp_data[i*DATA_W +: DATA_W]),
      .mask_q  (cmp_mask[i*DATA_W +: DATA_W])
    );
    assign cmp_en[i] = cmp_ctl[i*BYTE_W + EN_BIT];
  end

  dbgw_rdmux u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .win_sel    (win_sel),
    .bank_bytes (bank_bytes),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );
endmodule

// File: rtl/dbgw_chk.sv
module dbgw_chk
  import dbgw_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic [SEL_W-1:0]          win_sel,
  input logic                      req_valid,
  input logic                      req_write,
  input logic [OFF_W-1:0]          req_off,
  input logic [BYTE_W-1:0]         req_wdata,
  input logic                      rsp_valid,
  input logic [BYTE_W-1:0]         rsp_rdata,
  input logic [NUM_CMP-1:0]        cmp_en,
  input logic [NUM_CMP*BYTE_W-1:0] cmp_ctl,
  input logic [NUM_CMP*ADDR_W-1:0] cmp_addr,
  input logic [NUM_CMP*DATA_W-1:0] cmp_data,
  input logic [NUM_CMP*DATA_W-1:0] cmp_mask
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    rsp_valid == $past(req_valid && !req_write)) else $error("rsp timing"); // R9

  AST_LITE_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (rsp_valid && $past(win_sel[0] && (int'(req_off) >= DATA_OFF0))) |-> (rsp_rdata == '0))
    else $error("lite hole nonzero"); // R5

  AST_FULL_CTL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (rsp_valid && $past(!win_sel[0] && (req_off == '0))) |-> (rsp_rdata[7:6] == 2'b00))
    else $error("full ctl bits"); // R6

  AST_LITE_CTL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (rsp_valid && $past(win_sel[0] && (req_off == '0))) |-> (rsp_rdata[7:4] == 4'b0000))
    else $error("lite ctl bits"); // R7

  AST_UNSEL_B_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && (win_sel == SEL_W'(1))) |=> $stable(cmp_addr[ADDR_W +: ADDR_W]))
    else $error("B changed unselected"); // R2

  AST_LITE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_data[DATA_W +: DATA_W] == '0) && (cmp_mask[3*DATA_W +: DATA_W] == '0))
    else $error("lite data out"); // R5

  logic unused_ok;
  assign unused_ok = ^{req_wdata, cmp_en, cmp_ctl, cmp_data, cmp_mask};
endmodule

bind dbgw_window dbgw_chk u_chk (.*);

// File: tb/sim_dbgw_window.sv
`timescale 1ns/1ps
module sim_dbgw_window;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] win_sel = '0;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [2:0] req_off = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic [3:0] cmp_en;
  logic [31:0] cmp_ctl;
  logic [95:0] cmp_addr;
  logic [63:0] cmp_data;
  logic [63:0] cmp_mask;

  int tests = 0;
  int fails = 0;
  logic [7:0] mdl [4][8];

  always #2.5 clk = ~clk;

  dbgw_window u0 (
    .clk(clk), .rst_n(rst_n), .win_sel(win_sel), .req_valid(req_valid),
    .req_write(req_write), .req_off(req_off), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cmp_en(cmp_en),
    .cmp_ctl(cmp_ctl), .cmp_addr(cmp_addr), .cmp_data(cmp_data), .cmp_mask(cmp_mask)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(int b, int o);
    if (o == 0)     return (b % 2) ? "R7" : "R6";
    else if (o < 4) return "R3";
    else            return (b % 2) ? "R5" : "R4";
  endfunction

  function automatic void mdl_write(int b, int o, logic [7:0] d);
    if (o == 0)                  mdl[b][o] = d & ((b % 2) ? 8'h0F : 8'h3F);
    else if (o < 4 || b % 2 == 0) mdl[b][o] = d;
  endfunction

  task automatic do_write(int b, int o, logic [7:0] d);
    @(negedge clk);
    win_sel = 2'(b); req_valid = 1'b1; req_write = 1'b1;
    req_off = 3'(o); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    mdl_write(b, o, d);
    chk("R9 write raises no rsp", 32'(rsp_valid), 32'd0);
  endtask

  task automatic do_read(int b, int o, output logic [7:0] q);
    @(negedge clk);
    win_sel = 2'(b); req_valid = 1'b1; req_write = 1'b0; req_off = 3'(o);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 rsp_valid after read", 32'(rsp_valid), 32'd1);
    q = rsp_rdata;
    @(negedge clk);
    chk("R9 rsp_valid single cycle", 32'(rsp_valid), 32'd0);
  endtask

  task automatic sweep(string what);
    logic [7:0] q;
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 8; o++) begin
        do_read(b, o, q);
        chk($sformatf("R2 %s %s b%0d o%0d", what, tag_of(b, o), b, o), 32'(q), 32'(mdl[b][o]));
      end
  endtask

  task automatic check_outputs(string what);
    for (int b = 0; b < 4; b++) begin
      chk($sformatf("R8 %s en b%0d", what, b), 32'(cmp_en[b]), 32'(mdl[b][0][0]));
      chk($sformatf("R6 R7 %s ctl b%0d", what, b), 32'(cmp_ctl[b*8 +: 8]), 32'(mdl[b][0]));
      chk($sformatf("R3 %s addr b%0d", what, b), 32'(cmp_addr[b*24 +: 24]),
          32'({mdl[b][1], mdl[b][2], mdl[b][3]}));
      chk($sformatf("R4 R5 %s data b%0d", what, b), 32'(cmp_data[b*16 +: 16]),
          (b % 2) ? 32'd0 : 32'({mdl[b][4], mdl[b][5]}));
      chk($sformatf("R4 R5 %s mask b%0d", what, b), 32'(cmp_mask[b*16 +: 16]),
          (b % 2) ? 32'd0 : 32'({mdl[b][6], mdl[b][7]}));
    end
  endtask

  task automatic pass_run(int p);
    logic [7:0] d, q;
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 8; o++) begin
        if (p == 0)      d = 8'hFF;
        else if (p == 1) d = 8'(((b * 8 + o) * 29 + 7) ^ 8'hA5);
        else             d = 8'h00;
        do_write(b, o, d);
        do_read(b, o, q);
        chk($sformatf("R10 %s p%0d b%0d o%0d", tag_of(b, o), p, b, o), 32'(q), 32'(mdl[b][o]));
      end
    check_outputs($sformatf("pass%0d", p));
    sweep($sformatf("pass%0d", p));
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 8; o++) mdl[b][o] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset cmp_en", 32'(cmp_en), 32'd0);
    chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    check_outputs("R1 reset");
    sweep("R1 reset");
    for (int p = 0; p < 3; p++) pass_run(p);
    // enable one comparator at a time
    for (int b = 0; b < 4; b++) begin
      do_write(b, 0, 8'hC1);
      chk($sformatf("R8 single enable b%0d", b), 32'(cmp_en), 32'(4'b1 << b));
      do_write(b, 0, 8'h00);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule